// File: doc/BRIEF.md
# Dual-Port Host Bridge Control Register Bank

This block holds the 64-bit control and status registers of a host bridge and serves them to two requesters that share one access channel. Each request carries a source flag. A configuration-port request turns its byte address into a register index by dropping the three low bits. A memory-mapped request does the same and then adds a fixed offset of 0x0a. As a result, memory-mapped offset 0 lands on the window base register.

The bank has several special registers:
- A fault register, with write aliases that AND or OR data into it.
- A control register, with write aliases that set or clear bits in it.
- A window base register that only the configuration port may write. It drives the window enable and window base outputs.
- A masked secondary base register.
- A read-only interrupt status word.

The remaining implemented indices are stored unchanged and not interpreted. Read data comes back one cycle after the request with a valid strobe. Any dropped or illegal access raises a one-cycle error pulse in that same cycle.

Top module: `bridge_reg_bank`

## Requirements
- R1: The register index is `addr >> 3` for configuration requests (`acc_mm`=0) and `(addr >> 3) + 0x0a` for memory-mapped requests (`acc_mm`=1). An access whose `addr[2:0]` is not zero is not a full 8-byte access. Such an access has no effect, raises the error pulse, and a read of it returns all ones.
- R2: Every read request (`acc_req`=1, `acc_we`=0) produces `rd_valid` high for exactly the next cycle, with `rd_data` registered. Writes never raise `rd_valid`.
- R3: Index 0x00 is the fault register. A write to index 0x01 ANDs the data into it, and a write to index 0x02 ORs the data into it.
- R4: Index 0x0e is the control register. A write to index 0x12 ORs the data into it, and a write to index 0x13 clears the bits that are set in the data.
- R5: The window base register at index 0x0a is written only by configuration requests. A memory-mapped write to it leaves it unchanged and raises the error pulse.
- R6: The window base register stores `data & (0x0003fffffff00000 | 1)`. `win_en` is its bit 0. `win_base` is the stored value masked with 0x0003fffffff00000 while `win_en` is 1, and zero otherwise.
- R7: The secondary base register at index 0x0b stores `data & 0x0003ffff00000000`.
- R8: A read of an index that cannot be read returns all ones and raises the error pulse. The readable indices are 0x00, 0x06, 0x07, 0x0a, 0x0b, 0x0e, 0x0f, 0x10, 0x14, 0x15 and 0x16 to 0x1b. The alias indices 0x01, 0x02, 0x12 and 0x13 are write-only. A write to any index that is neither readable nor an alias is dropped and raises the error pulse.
- R9: The status register at index 0x15 reads as zero. A write to it is dropped and raises the error pulse.
- R10: After reset, every register is zero except the window base register, which holds `RESET_BASE` masked as in R6 with bit 0 set.
- R11: The plain indices 0x06, 0x07, 0x0f, 0x10, 0x14 and 0x16 to 0x1b store all 64 written bits.
- R12: `err_pulse` is high for exactly one cycle, the cycle after the offending request. A legal access never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_req | input | 1 | Access request this cycle |
| acc_mm | input | 1 | Request source: 1 = memory-mapped, 0 = configuration |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte address within the port's space |
| acc_wdata | input | 64 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 64 | Registered read data |
| err_pulse | output | 1 | One-cycle error for a dropped or illegal access |
| win_en | output | 1 | Window enable (bit 0 of the window base register) |
| win_base | output | 64 | Window base address, zero while disabled |

## Verification
The bench builds the block with `ADDR_W` = 8 and a non-zero `RESET_BASE`. With that width, the configuration port covers every index from 0x00 to 0x1f. The memory-mapped port covers indices 0x0a to 0x29, so both decodes and the out-of-range indices above the register file can be swept exhaustively. With these values the sweeps reach:
- every read and write path;
- the port-specific write restriction on the window base register;
- both pairs of alias operations;
- misaligned addresses.

All expected results come from an arithmetic model kept in the bench.

// File: rtl/brb_pkg.sv
package brb_pkg;

   localparam int REG_SLOTS = 32;
   localparam int IX_BASE   = 'h0a;
   localparam int IX_STAT   = 'h15;

   typedef enum logic [3:0] {
      RK_NONE,
      RK_FAULT,
      RK_FAULT_AND,
      RK_FAULT_OR,
      RK_BASE,
      RK_SEC,
      RK_CTRL,
      RK_CTRL_SET,
      RK_CTRL_CLR,
      RK_STAT,
      RK_PLAIN
   } reg_kind_e;

   function automatic reg_kind_e kind_of(input int ix);
      reg_kind_e k;
      case (ix)
         'h00:    k = RK_FAULT;
         'h01:    k = RK_FAULT_AND;
         'h02:    k = RK_FAULT_OR;
         'h0a:    k = RK_BASE;
         'h0b:    k = RK_SEC;
         'h0e:    k = RK_CTRL;
         'h12:    k = RK_CTRL_SET;
         'h13:    k = RK_CTRL_CLR;
         'h15:    k = RK_STAT;
         'h06, 'h07, 'h0f, 'h10, 'h14,
         'h16, 'h17, 'h18, 'h19, 'h1a, 'h1b:
                  k = RK_PLAIN;
         default: k = RK_NONE;
      endcase
      return k;
   endfunction

endpackage

// File: rtl/brb_idx_map.sv
module brb_idx_map #(
   parameter int ADDR_W = 8,
   parameter int IDX_W  = 6,
   parameter int MM_OFS = 10
) (
   input  logic              src_mm,
   input  logic [ADDR_W-1:0] addr,
   output logic [IDX_W-1:0]  idx,
   output logic              aligned
);
   localparam int WORD_W = ADDR_W - 3;

   logic [IDX_W-1:0] word;

   assign word    = {{(IDX_W-WORD_W){1'b0}}, addr[ADDR_W-1:3]};
   assign idx     = src_mm ? word + IDX_W'(MM_OFS) : word;
   assign aligned = (addr[2:0] == 3'b000);

endmodule

// File: rtl/brb_regs.sv
module brb_regs
   import brb_pkg::*;
#(
   parameter int          IDX_W      = 6,
   parameter logic [63:0] BASE_MASK  = 64'h0003_ffff_fff0_0000,
   parameter logic [63:0] SEC_MASK   = 64'h0003_ffff_0000_0000,
   parameter logic [63:0] RESET_BASE = 64'h0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_req,
   input  logic             acc_we,
   input  logic             acc_mm,
   input  logic             acc_ok,
   input  logic [IDX_W-1:0] idx,
   input  logic [63:0]      wdata,
   output logic [63:0]      rd_word,
   output logic             acc_err,
   output logic [63:0]      base_q
);
   localparam logic [63:0] BASE_KEEP = BASE_MASK | 64'h1;

   reg_kind_e   kind;
   logic        in_range;
   logic        wr_drop;
   logic        rd_bad;
   logic        wr_fire;
   logic [63:0] fault_q;
   logic [63:0] ctrl_q;
   logic [63:0] sec_q;
   logic [63:0] slot [REG_SLOTS];

   assign in_range = (int'(idx) < REG_SLOTS);
   assign kind     = in_range ? kind_of(int'(idx)) : RK_NONE;

   assign wr_drop  = !acc_ok || (kind == RK_NONE) || (kind == RK_STAT) ||
                     ((kind == RK_BASE) && acc_mm);
   assign rd_bad   = !acc_ok || (kind == RK_NONE) || (kind == RK_FAULT_AND) ||
                     (kind == RK_FAULT_OR) || (kind == RK_CTRL_SET) ||
                     (kind == RK_CTRL_CLR);
   assign wr_fire  = acc_req && acc_we && !wr_drop;
   assign acc_err  = acc_req && (acc_we ? wr_drop : rd_bad);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fault_q <= '0;
         ctrl_q  <= '0;
         sec_q   <= '0;
         base_q  <= (RESET_BASE & BASE_MASK) | 64'h1;
      end else if (wr_fire) begin
         case (kind)
            RK_FAULT:     fault_q <= wdata;
            RK_FAULT_AND: fault_q <= fault_q & wdata;
            RK_FAULT_OR:  fault_q <= fault_q | wdata;
            RK_CTRL:      ctrl_q  <= wdata;
            RK_CTRL_SET:  ctrl_q  <= ctrl_q | wdata;
            RK_CTRL_CLR:  ctrl_q  <= ctrl_q & ~wdata;
            RK_SEC:       sec_q   <= wdata & SEC_MASK;
            RK_BASE:      base_q  <= wdata & BASE_KEEP;
            default:      ;
         endcase
      end
   end

   for (genvar g = 0; g < REG_SLOTS; g++) begin : g_slot
      if (kind_of(g) == RK_PLAIN) begin : g_plain
         logic [63:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               q <= '0;
            end else if (wr_fire && (int'(idx) == g)) begin
               q <= wdata;
            end
         end
         assign slot[g] = q;
      end else begin : g_empty
         assign slot[g] = '0;
      end
   end

   always_comb begin
      case (kind)
         RK_FAULT: rd_word = fault_q;
         RK_CTRL:  rd_word = ctrl_q;
         RK_SEC:   rd_word = sec_q;
         RK_BASE:  rd_word = base_q;
         RK_STAT:  rd_word = '0;
         RK_PLAIN: rd_word = slot[idx[4:0]];
         default:  rd_word = '1;
      endcase
      if (!acc_ok) begin
         rd_word = '1;
      end
   end

endmodule

// File: rtl/brb_resp.sv
module brb_resp #(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_fire,
   input  logic              err_now,
   input  logic [DATA_W-1:0] rd_word,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              err_pulse
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid  <= 1'b0;
         rd_data   <= '0;
         err_pulse <= 1'b0;
      end else begin
         rd_valid  <= rd_fire;
         err_pulse <= err_now;
         if (rd_fire) begin
            rd_data <= rd_word;
         end
      end
   end
endmodule

// File: rtl/bridge_reg_bank.sv
module bridge_reg_bank #(
   parameter int          DATA_W     = 64,
   parameter int          ADDR_W     = 8,
   parameter int          MM_OFS     = 10,
   parameter logic [63:0] BASE_MASK  = 64'h0003_ffff_fff0_0000,
   parameter logic [63:0] SEC_MASK   = 64'h0003_ffff_0000_0000,
   parameter logic [63:0] RESET_BASE = 64'h0000_0000_0000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_req,
   input  logic              acc_mm,
   input  logic              acc_we,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [63:0]       acc_wdata,
   output logic              rd_valid,
   output logic [63:0]       rd_data,
   output logic              err_pulse,
   output logic              win_en,
   output logic [63:0]       win_base
);
   localparam int IDX_W = (ADDR_W - 2 > 6) ? ADDR_W - 2 : 6;

   if (DATA_W != 64) begin : g_bad_data
      $error("bridge_reg_bank: registers are 64 bits wide");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("bridge_reg_bank: ADDR_W must reach every register index");
   end
   if (MM_OFS < 0 || MM_OFS > 10) begin : g_bad_ofs
      $error("bridge_reg_bank: MM_OFS out of range");
   end

   logic [IDX_W-1:0] idx;
   logic             aligned;
   logic [63:0]      rd_word;
   logic             acc_err;
   logic [63:0]      base_q;

   brb_idx_map #(
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W),
      .MM_OFS (MM_OFS)
   ) map_i (
      .src_mm  (acc_mm),
      .addr    (acc_addr),
      .idx     (idx),
      .aligned (aligned)
   );

   brb_regs #(
      .IDX_W      (IDX_W),
      .BASE_MASK  (BASE_MASK),
      .SEC_MASK   (SEC_MASK),
      .RESET_BASE (RESET_BASE)
   ) regs_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .acc_req (acc_req),
      .acc_we  (acc_we),
      .acc_mm  (acc_mm),
      .acc_ok  (aligned),
      .idx     (idx),
      .wdata   (acc_wdata),
      .rd_word (rd_word),
      .acc_err (acc_err),
      .base_q  (base_q)
   );

   brb_resp #(
      .DATA_W (64)
   ) resp_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_fire   (acc_req && !acc_we),
      .err_now   (acc_err),
      .rd_word   (rd_word),
      .rd_valid  (rd_valid),
      .rd_data   (rd_data),
      .err_pulse (err_pulse)
   );

   assign win_en   = base_q[0];
   assign win_base = base_q[0] ? (base_q & BASE_MASK) : '0;

endmodule

// File: rtl/bridge_reg_bank_chk.sv
module bridge_reg_bank_chk #(
   parameter int          ADDR_W    = 8,
   parameter int          MM_OFS    = 10,
   parameter logic [63:0] BASE_MASK = 64'h0003_ffff_fff0_0000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_req,
   input logic              acc_mm,
   input logic              acc_we,
   input logic [ADDR_W-1:0] acc_addr,
   input logic              rd_valid,
   input logic              err_pulse,
   input logic              win_en,
   input logic [63:0]       win_base
);
   localparam logic [ADDR_W-1:0] MM_BASE_ADDR = ADDR_W'((brb_pkg::IX_BASE - MM_OFS) * 8);
   localparam logic [ADDR_W-1:0] CFG_STAT_ADDR = ADDR_W'(brb_pkg::IX_STAT * 8);

   // R2
   rd_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_req && !acc_we) |=> rd_valid);

   // R2
   no_stray_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_req && !acc_we) |=> !rd_valid);

   // R12
   err_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_req |=> !err_pulse);

   // R5
   mm_base_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_req && acc_mm && acc_we && acc_addr == MM_BASE_ADDR)
      |=> ($stable(win_en) && $stable(win_base) && err_pulse));

   // R6
   base_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !win_en |-> (win_base == 64'h0));

   // R6
   base_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_base & ~BASE_MASK) == 64'h0);

   // R9
   stat_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_req && !acc_mm && acc_we && acc_addr == CFG_STAT_ADDR) |=> err_pulse);

endmodule

bind bridge_reg_bank bridge_reg_bank_chk #(
   .ADDR_W    (ADDR_W),
   .MM_OFS    (MM_OFS),
   .BASE_MASK (BASE_MASK)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_req   (acc_req),
   .acc_mm    (acc_mm),
   .acc_we    (acc_we),
   .acc_addr  (acc_addr),
   .rd_valid  (rd_valid),
   .err_pulse (err_pulse),
   .win_en    (win_en),
   .win_base  (win_base)
);

// File: tb/bridge_reg_bank_tb_top.sv
module bridge_reg_bank_tb_top;
   localparam int          AW    = 8;
   localparam logic [63:0] BMASK = 64'h0003_ffff_fff0_0000;
   localparam logic [63:0] SMASK = 64'h0003_ffff_0000_0000;
   localparam logic [63:0] RBASE = 64'h0001_2345_6780_0000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          acc_req = 1'b0;
   logic          acc_mm = 1'b0;
   logic          acc_we = 1'b0;
   logic [AW-1:0] acc_addr = '0;
   logic [63:0]   acc_wdata = '0;
   logic          rd_valid;
   logic [63:0]   rd_data;
   logic          err_pulse;
   logic          win_en;
   logic [63:0]   win_base;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;
   logic [63:0] m [32];

   always #4 clk = ~clk;

   bridge_reg_bank #(
      .ADDR_W     (AW),
      .RESET_BASE (RBASE)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_req   (acc_req),
      .acc_mm    (acc_mm),
      .acc_we    (acc_we),
      .acc_addr  (acc_addr),
      .acc_wdata (acc_wdata),
      .rd_valid  (rd_valid),
      .rd_data   (rd_data),
      .err_pulse (err_pulse),
      .win_en    (win_en),
      .win_base  (win_base)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic bit readable(input int ix);
      return ix inside {0, 6, 7, 10, 11, 14, 15, 16, 20, 21, 22, 23, 24, 25, 26, 27};
   endfunction

   function automatic string tag_for(input int ix);
      if (ix <= 2) return "R3";
      if (ix == 10) return "R5";
      if (ix == 11) return "R7";
      if (ix == 14 || ix == 18 || ix == 19) return "R4";
      if (ix == 21) return "R9";
      if (ix inside {6, 7, 15, 16, 20, 22, 23, 24, 25, 26, 27}) return "R11";
      return "R8";
   endfunction

   // model update for a write; returns whether the write is legal
   function automatic bit model_write(input bit mm, input int ix, input logic [63:0] d);
      case (ix)
         0:  m[0] = d;
         1:  m[0] = m[0] & d;
         2:  m[0] = m[0] | d;
         10: if (mm) return 1'b0; else m[10] = d & (BMASK | 64'h1);
         11: m[11] = d & SMASK;
         14: m[14] = d;
         18: m[14] = m[14] | d;
         19: m[14] = m[14] & ~d;
         6, 7, 15, 16, 20, 22, 23, 24, 25, 26, 27: m[ix] = d;
         default: return 1'b0;
      endcase
      return 1'b1;
   endfunction

   task automatic check_window(input string tag);
      chk({tag, " win_en"}, {63'h0, win_en}, {63'h0, m[10][0]});
      chk({tag, " win_base"}, win_base, m[10][0] ? (m[10] & BMASK) : 64'h0);
   endtask

   task automatic acc(input bit mm, input bit we, input logic [AW-1:0] a,
                      input logic [63:0] d, input string tag_in);
      int ix;
      bit ok;
      logic [63:0] exp_d;
      string tag;
      ix = int'(a >> 3) + (mm ? 10 : 0);
      tag = (a[2:0] != 0) ? "R1" : (tag_in.len() > 0 ? tag_in : tag_for(ix));
      if (we) begin
         ok = (a[2:0] == 0) && (ix < 32) && model_write(mm, ix, d);
         exp_d = '0;
      end else begin
         ok = (a[2:0] == 0) && (ix < 32) && readable(ix);
         exp_d = ok ? m[ix] : 64'hffff_ffff_ffff_ffff;
      end
      @(negedge clk);
      acc_req = 1'b1; acc_mm = mm; acc_we = we; acc_addr = a; acc_wdata = d;
      @(negedge clk);
      acc_req = 1'b0; acc_we = 1'b0;
      // R2 valid strobe one cycle after a read, never after a write
      chk({tag, " rd_valid"}, {63'h0, rd_valid}, {63'h0, !we});
      if (!we) chk({tag, " rd_data"}, rd_data, exp_d);
      // R12 error only for illegal accesses
      chk({tag, " err_pulse"}, {63'h0, err_pulse}, {63'h0, !ok});
      @(negedge clk);
      chk("R12 pulse end", {62'h0, err_pulse, rd_valid}, 64'h0);
      check_window(tag);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not finish actual=hung expected=done");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 32; i++) m[i] = '0;
      m[10] = (RBASE & BMASK) | 64'h1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R10 reset state at the ports
      chk("R10 rd_valid", {63'h0, rd_valid}, 64'h0);
      chk("R10 err", {63'h0, err_pulse}, 64'h0);
      check_window("R10");

      // R10 / R8: every configuration index after reset
      for (int i = 0; i < 32; i++) acc(1'b0, 1'b0, AW'(i * 8), '0, "R10");
      // R1 misaligned reads on both ports
      acc(1'b0, 1'b0, 8'h03, '0, "");
      acc(1'b1, 1'b0, 8'h05, '0, "");

      // write sweep through the configuration port
      for (int i = 0; i < 32; i++)
         acc(1'b0, 1'b1, AW'(i * 8),
             64'hfedc_ba98_7654_3211 ^ (64'h0101_0101_0101_0101 * 64'(i)), "");
      // R1 memory-mapped decode across its whole space
      for (int i = 0; i < 32; i++) acc(1'b1, 1'b0, AW'(i * 8), '0, "");
      for (int i = 0; i < 32; i++) acc(1'b0, 1'b0, AW'(i * 8), '0, "");

      // R3 fault aliases
      acc(1'b0, 1'b1, 8'h00, 64'hf0f0_f0f0_0000_ffff, "R3");
      acc(1'b0, 1'b1, 8'h08, 64'hff00_ff00_ff00_ff0f, "R3");
      acc(1'b0, 1'b1, 8'h10, 64'h000f_0000_0001_0000, "R3");
      acc(1'b0, 1'b0, 8'h00, '0, "R3");

      // R4 control aliases through the memory-mapped port
      acc(1'b1, 1'b1, 8'h20, 64'h8000_0000_0000_0001, "R4");
      acc(1'b1, 1'b1, 8'h40, 64'h0400_0800_0000_0010, "R4");
      acc(1'b1, 1'b1, 8'h48, 64'h8000_0800_0000_0000, "R4");
      acc(1'b1, 1'b0, 8'h20, '0, "R4");

      // R5 memory-mapped write to the window base is dropped
      acc(1'b0, 1'b1, 8'h50, 64'hffff_ffff_ffff_ffff, "R6");
      acc(1'b1, 1'b1, 8'h00, 64'h0000_0000_0000_0000, "R5");
      acc(1'b1, 1'b0, 8'h00, '0, "R5");
      // R6 window disabled, then re-enabled
      acc(1'b0, 1'b1, 8'h50, 64'h0002_0000_0010_0000, "R6");
      acc(1'b0, 1'b1, 8'h50, 64'h0002_0000_0010_0001, "R6");

      // R7 secondary base masking via the memory-mapped port
      acc(1'b1, 1'b1, 8'h08, 64'hffff_ffff_ffff_ffff, "R7");
      acc(1'b0, 1'b0, 8'h58, '0, "R7");

      // R9 status write from the memory-mapped port
      acc(1'b1, 1'b1, 8'h58, 64'hffff_ffff_ffff_ffff, "R9");
      acc(1'b0, 1'b0, 8'ha8, '0, "R9");

      // R1 misaligned write must not touch the fault register
      acc(1'b0, 1'b1, 8'h04, 64'h1234_5678_9abc_def0, "R1");
      acc(1'b0, 1'b0, 8'h00, '0, "R1");

      // R11 full-width storage on plain indices
      acc(1'b0, 1'b1, 8'hd8, 64'h8000_0000_0000_0001, "R11");
      acc(1'b1, 1'b0, 8'h88, '0, "R11");

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule